// File: doc/BRIEF.md
# Digit-Serial Redundant-Basis Field Multiplier

This block multiplies two field elements that are held as N-coordinate vectors over GF(2). Multiplication is taken in the ring GF(2)[x]/(x^N+1), with N odd. No modular reduction step is needed, because the cyclic index map already closes the product into N coordinates. Coordinate i of the product is the XOR, over all j, of a_j AND b_((i-j) mod N).

Operand B and the single coordinate a_0 are captured in parallel when a start pulse arrives. The other coordinates of A come in as symmetric pairs, W pairs per accepted digit. A pair is a_k and a_(N-k) for k from 1 to (N-1)/2. Each output coordinate has its own accumulator slice. The slice holds one lane for the a_0 term and W two-lane structures, one for each pair slot. Every lane is an AND gate feeding an XOR gate, with a flip-flop fed back into that XOR. Two rotating copies of B feed the lanes through fixed wiring, so that every slot sees the correct B index on each digit. The N-bit product is formed by an XOR tree over all lanes and is presented in parallel. A done pulse marks that the product is complete.

Top module: `rb_digit_mult`

## Requirements
- R1: After reset, product_o is all zeros and busy_o and done_o are low.
- R2: A start_i pulse captures b_i and a0_i and clears every pair accumulator. busy_o is high in the following cycle. start_i takes priority over a digit presented in the same cycle.
- R3: Digit t, counted from 0 after start, carries a_k on digit_i bit l and a_(N-k) on digit_i bit W+l, where k = t*W + l + 1 and l runs from 0 to W-1.
- R4: After ceil(((N-1)/2)/W) accepted digits, product_o equals the XOR over j of a_j AND b_((i-j) mod N) for every coordinate i.
- R5: A digit slot whose k exceeds (N-1)/2 is padding. Both of its bits have no effect on the product.
- R6: A cycle with digit_valid_i low while busy_o is high consumes no digit and does not advance the digit count.
- R7: done_o is high for exactly one cycle: the cycle after the clock edge that accepts the last digit. busy_o is already low in that cycle.
- R8: While busy_o is low and start_i is low, product_o holds its value, and any digits presented are ignored.
- R9: A start_i pulse while busy_o is high abandons the current product. The block then computes the new product from the operands presented with that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a product; captures b_i and a0_i |
| b_i | input | N | Operand B, all coordinates |
| a0_i | input | 1 | Coordinate a_0 of operand A |
| digit_valid_i | input | 1 | digit_i holds the next digit |
| digit_i | input | 2*W | W symmetric coordinate pairs of A (R3 layout) |
| busy_o | output | 1 | Digits are being accepted |
| done_o | output | 1 | One-cycle pulse: the product is complete |
| product_o | output | N | Parallel product |

## Verification
A wrong rotation step in either B copy, or a miswired tap, corrupts only the terms of a single slot on a given digit. Such an error shows up as a few flipped product coordinates in the done cycle, and only for operands whose pair coordinates are non-zero in that slot. For this reason, single-coordinate operands are mixed with random ones. A digit counter that skips a stall, or that miscounts, moves the done pulse by a cycle or more. It also either drops the last pairs or leaks the padding bits into the product. Both effects can be seen at the first completed product.

// File: rtl/rb_mul_pkg.sv
package rb_mul_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int half_len(input int n);
    return (n - 1) / 2;
  endfunction
endpackage

// File: rtl/rb_mul_ctrl.sv
module rb_mul_ctrl
  import rb_mul_pkg::*;
#(
  parameter int N = 11,
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         digit_valid_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         step_o,
  output logic [W-1:0] slot_en_o
);
  localparam int H    = half_len(N);
  localparam int NDIG = ceil_div(H, W);
  localparam int CW   = (NDIG > 1) ? $clog2(NDIG) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign step_o = busy_q & digit_valid_i & ~start_i;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (step_o) begin
        if (cnt_q == CW'(NDIG - 1)) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // pair index k = cnt*W + l + 1; slots past H are padding
  for (genvar l = 0; l < W; l++) begin : g_slot
    assign slot_en_o[l] = ((int'(cnt_q) * W + l + 1) <= H);
  end

  assert_busy_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_restart_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0));
  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !digit_valid_i && !start_i) |=> ($stable(cnt_q) && busy_q));
  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(cnt_q) < NDIG));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/rb_mul_rotator.sv
module rb_mul_rotator #(
  parameter int N = 11,
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         step_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] bp_o,
  output logic [N-1:0] bm_o
);
  localparam int SH = W % N;

  logic [N-1:0] bp_q, bm_q, bp_d, bm_d;

  // bp[m] tracks b[m - t*W], bm[m] tracks b[m + t*W] at digit t
  for (genvar m = 0; m < N; m++) begin : g_rot
    assign bp_d[m] = bp_q[(m + N - SH) % N];
    assign bm_d[m] = bm_q[(m + SH) % N];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q <= '0;
      bm_q <= '0;
    end else if (start_i) begin
      bp_q <= b_i;
      bm_q <= b_i;
    end else if (step_i) begin
      bp_q <= bp_d;
      bm_q <= bm_d;
    end
  end

  assign bp_o = bp_q;
  assign bm_o = bm_q;

  assert_b_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((bp_q == $past(b_i)) && (bm_q == $past(b_i))));
endmodule

// File: rtl/rb_mul_slice.sv
module rb_mul_slice #(
  parameter int W = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           step_i,
  input  logic           a0_i,
  input  logic           b_self_i,
  input  logic [W-1:0]   slot_en_i,
  input  logic [2*W-1:0] digit_i,
  input  logic [W-1:0]   tap_p_i,
  input  logic [W-1:0]   tap_m_i,
  output logic           coord_o
);
  logic         acc0_q;
  logic [W-1:0] acc_p_q, acc_m_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc0_q <= 1'b0;
    else if (start_i) acc0_q <= a0_i & b_self_i;
  end

  // one structure per slot: lane p takes a_k, lane m takes a_(N-k)
  for (genvar l = 0; l < W; l++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_p_q[l] <= 1'b0;
        acc_m_q[l] <= 1'b0;
      end else if (start_i) begin
        acc_p_q[l] <= 1'b0;
        acc_m_q[l] <= 1'b0;
      end else if (step_i) begin
        acc_p_q[l] <= acc_p_q[l] ^ (slot_en_i[l] & digit_i[l]     & tap_p_i[l]);
        acc_m_q[l] <= acc_m_q[l] ^ (slot_en_i[l] & digit_i[W + l] & tap_m_i[l]);
      end
    end
  end

  assign coord_o = acc0_q ^ (^acc_p_q) ^ (^acc_m_q);

  assert_clear_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((acc_p_q == '0) && (acc_m_q == '0)));
endmodule

// File: rtl/rb_digit_mult.sv
module rb_digit_mult #(
  parameter int N = 11,
  parameter int W = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   b_i,
  input  logic           a0_i,
  input  logic           digit_valid_i,
  input  logic [2*W-1:0] digit_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N-1:0]   product_o
);
  if ((N % 2) == 0 || N < 3 || W < 1 || W > 8) begin : g_bad_param
    $error("rb_digit_mult: N must be odd and >= 3, W in 1..8");
  end

  logic         step;
  logic [W-1:0] slot_en;
  logic [N-1:0] bp, bm, coord;
  logic [W-1:0] tap_p [N];
  logic [W-1:0] tap_m [N];

  rb_mul_ctrl #(.N(N), .W(W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .digit_valid_i (digit_valid_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .step_o        (step),
    .slot_en_o     (slot_en)
  );

  rb_mul_rotator #(.N(N), .W(W)) u_rot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .step_i  (step),
    .b_i     (b_i),
    .bp_o    (bp),
    .bm_o    (bm)
  );

  // fixed expansion wiring: slot l of coordinate i reads b[i-(l+1)] and b[i+(l+1)]
  for (genvar i = 0; i < N; i++) begin : g_coord
    for (genvar l = 0; l < W; l++) begin : g_tap
      localparam int OFF = (l + 1) % N;
      assign tap_p[i][l] = bp[(i + N - OFF) % N];
      assign tap_m[i][l] = bm[(i + OFF) % N];
    end

    rb_mul_slice #(.W(W)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .step_i    (step),
      .a0_i      (a0_i),
      .b_self_i  (b_i[i]),
      .slot_en_i (slot_en),
      .digit_i   (digit_i),
      .tap_p_i   (tap_p[i]),
      .tap_m_i   (tap_m[i]),
      .coord_o   (coord[i])
    );
  end

  assign product_o = coord;

  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));
endmodule

// File: tb/rb_digit_mult_tb.sv
module rb_digit_mult_tb;
  localparam int N    = 11;
  localparam int W    = 2;
  localparam int H    = (N - 1) / 2;
  localparam int NDIG = (H + W - 1) / W;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [N-1:0]   b_i = '0;
  logic           a0_i = 1'b0;
  logic           digit_valid_i = 1'b0;
  logic [2*W-1:0] digit_i = '0;
  logic           busy_o, done_o;
  logic [N-1:0]   product_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  rb_digit_mult #(.N(N), .W(W)) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .b_i (b_i), .a0_i (a0_i),
    .digit_valid_i (digit_valid_i), .digit_i (digit_i),
    .busy_o (busy_o), .done_o (done_o), .product_o (product_o)
  );

  function automatic logic [N-1:0] conv(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] c = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        c[i] ^= a[j] & b[(i - j + N) % N];
    return c;
  endfunction

  // R3 layout; R5 padding slots filled with random bits
  function automatic logic [2*W-1:0] mk_digit(input logic [N-1:0] a, input int t);
    logic [2*W-1:0] d;
    for (int l = 0; l < W; l++) begin
      int k = t * W + l + 1;
      if (k <= H) begin
        d[l]     = a[k];
        d[W + l] = a[N - k];
      end else begin
        d[l]     = 1'($urandom);
        d[W + l] = 1'($urandom);
      end
    end
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input int stall_pct);
    @(negedge clk);
    start_i = 1'b1; b_i = b; a0_i = a[0];
    digit_valid_i = 1'($urandom); digit_i = 2*W'($urandom); // start wins (R2)
    @(negedge clk);
    start_i = 1'b0; b_i = N'($urandom); a0_i = 1'($urandom);
    chk(busy_o === 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
    for (int t = 0; t < NDIG; t++) begin
      while (int'($urandom % 100) < stall_pct) begin
        digit_valid_i = 1'b0; digit_i = 2*W'($urandom);
        @(negedge clk);
      end
      chk(done_o === 1'b0 && busy_o === 1'b1, "R6 busy during digits", 64'({busy_o, done_o}), 64'd2);
      digit_valid_i = 1'b1; digit_i = mk_digit(a, t);
      @(negedge clk);
    end
    digit_valid_i = 1'b0;
    chk(done_o === 1'b1 && busy_o === 1'b0, "R7 done after last digit", 64'({busy_o, done_o}), 64'd1);
    chk(product_o === conv(a, b), "R4 product", 64'(product_o), 64'(conv(a, b)));
    @(negedge clk);
    chk(done_o === 1'b0, "R7 done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    #400000000;
    n_err++;
    $display("FAIL R7 watchdog: done never reached, actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [N-1:0] ra, rb, hold;
    void'($urandom(32'd1789));
    repeat (3) @(negedge clk);
    chk(product_o === '0 && busy_o === 1'b0 && done_o === 1'b0, "R1 reset state",
        64'({product_o, busy_o, done_o}), 64'd0);
    rst_ni = 1'b1;

    rb = N'($urandom);
    run_op(N'(1), rb, 0);              // R2 a0 term only
    run_op(N'(2), rb, 0);              // R3 single low pair coordinate
    run_op(N'(1) << (N - 1), rb, 30);  // R3 single high pair coordinate
    run_op(N'(1) << H, rb, 0);         // R5 last real slot before padding
    run_op('0, rb, 0);                 // R5 padding bits only
    run_op('1, '1, 0);                 // R4 all ones

    // R8 digits while idle are ignored
    hold = product_o;
    repeat (4) begin
      @(negedge clk);
      digit_valid_i = 1'b1; digit_i = 2*W'($urandom);
    end
    @(negedge clk);
    digit_valid_i = 1'b0;
    chk(product_o === hold && busy_o === 1'b0 && done_o === 1'b0, "R8 idle ignores digits",
        64'(product_o), 64'(hold));

    // R9 restart mid-product
    @(negedge clk);
    start_i = 1'b1; b_i = N'($urandom); a0_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; digit_valid_i = 1'b1; digit_i = '1;
    @(negedge clk);
    digit_valid_i = 1'b0;
    ra = N'($urandom); rb = N'($urandom);
    run_op(ra, rb, 0);                 // R9 result from new operands

    for (int v = 0; v < 300; v++) begin
      ra = N'($urandom); rb = N'($urandom);
      run_op(ra, rb, (v % 3) * 25);    // R4, R6 random with stalls
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule